// File: doc/BRIEF.md
# DMA Interrupt Enable and Status Registers

This block holds the shared interrupt state of a sixteen-channel DMA controller. The controller has two channel groups of eight: normal channels and dedicated channels. Each channel reports two one-cycle events to this block: one when half of its transfer is done and one when the transfer ends.

The block latches every event into a 32-bit pending register. Software clears pending bits by writing ones to them. A 32-bit enable register selects which pending bits drive the single level interrupt line.

Each channel owns two adjacent status bits: the half-done bit is even and the end bit is odd. Normal channels fill bits 15..0 and dedicated channels fill bits 31..16. A read-only helper output names the lowest-numbered channel that has its end bit pending, as a group and an index, so an interrupt handler can go straight to it.

Both registers sit on a simple word-addressed register bus. Reads are combinational from the word address. Writes take effect on the clock edge.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, the enable register and the pending register both read 0, `irq_o` is 0 and `end_valid_o` is 0.
- R2: Channel c is numbered group*8 + index, where group 0 is normal and group 1 is dedicated. An end pulse on channel c sets pending bit 2c+1 on the next clock edge, so the end bits form the mask 0xAAAAAAAA. A half-done pulse on channel c sets pending bit 2c.
- R3: A pending bit is set by its event whether or not its enable bit is set. A bit that is pending but not enabled does not raise `irq_o`.
- R4: A write to word address 1 (byte offset 0x04) clears every pending bit that is 1 in the written data. All other pending bits are left unchanged.
- R5: When an event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R6: A write to word address 0 (byte offset 0x00) replaces the whole enable register. Word 0 reads back the enable register and word 1 reads back the pending register.
- R7: `irq_o` is 1 exactly when some bit is set in both the pending and the enable registers. It follows a register update in the same cycle as the new register value.
- R8: `end_valid_o` is 1 when any end bit (odd bit) is pending. For the lowest such bit p (p counted from 1), `end_type_o` = ((p-1)/2)/8 and `end_index_o` = ((p-1)/2)%8. Half-done bits are ignored.
- R9: Word addresses other than 0 and 1 read as zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Word address: 0 enable, 1 pending |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| half_evt_i | input | 16 | Half-done pulse for each channel, indexed group*8+index |
| end_evt_i | input | 16 | End pulse for each channel, indexed group*8+index |
| irq_o | output | 1 | Level interrupt |
| end_valid_o | output | 1 | Some end bit is pending |
| end_type_o | output | 1 | Group of the lowest pending end channel |
| end_index_o | output | 3 | Index of the lowest pending end channel |

## Verification
The assertions assume that event inputs are synchronous one-cycle pulses. They also assume that the register bus presents at most one write per cycle, with address and data held stable around the edge.

The stimulus drives every input on the falling edge, so each rising edge samples settled values. Events are drawn as sparse random masks, which often collide with clearing writes on the same bit. Addresses cover both registers and two unmapped words.

A behavioural reference model, built from integer loops over channel numbers, predicts both registers, the interrupt and the helper outputs after every rising edge.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int N_TYPES_DEF = 2;
  localparam int CH_PER_TYPE_DEF = 8;
  localparam int ADDR_W_DEF = 4;
  localparam int EN_WORD = 0;
  localparam int PEND_WORD = 1;

  function automatic int clog2_min1(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/dma_irq_bitmap.sv
module dma_irq_bitmap #(
  parameter int NCH = 16
) (
  input  logic [NCH-1:0]   half_i,
  input  logic [NCH-1:0]   end_i,
  output logic [2*NCH-1:0] set_o
);
  // two bits per channel: even = half-done, odd = end
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign set_o[2*c]   = half_i[c];
    assign set_o[2*c+1] = end_i[c];
  end
endmodule

// File: rtl/dma_irq_pend.sv
module dma_irq_pend #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i | clr_i) == '0) |=> $stable(pend_q));
endmodule

// File: rtl/dma_irq_lowest_end.sv
module dma_irq_lowest_end #(
  parameter int N_TYPES     = 2,
  parameter int CH_PER_TYPE = 8,
  localparam int NCH    = N_TYPES * CH_PER_TYPE,
  localparam int TYPE_W = dma_irq_pkg::clog2_min1(N_TYPES),
  localparam int IDX_W  = dma_irq_pkg::clog2_min1(CH_PER_TYPE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2*NCH-1:0]  pend_i,
  output logic              valid_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [IDX_W-1:0]  index_o
);
  logic [NCH-1:0] end_pend;

  for (genvar c = 0; c < NCH; c++) begin : g_odd
    assign end_pend[c] = pend_i[2*c+1];
  end

  // scan down so the lowest channel is the final assignment
  always_comb begin
    valid_o = 1'b0;
    type_o  = '0;
    index_o = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (end_pend[c]) begin
        valid_o = 1'b1;
        type_o  = TYPE_W'(c / CH_PER_TYPE);
        index_o = IDX_W'(c % CH_PER_TYPE);
      end
    end
  end

  assert_helper_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pend_i[2*(int'(type_o)*CH_PER_TYPE + int'(index_o)) + 1]);

  assert_helper_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_pend == '0) |-> !valid_o);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int N_TYPES     = N_TYPES_DEF,
  parameter int CH_PER_TYPE = CH_PER_TYPE_DEF,
  parameter int ADDR_W      = ADDR_W_DEF,
  localparam int NCH    = N_TYPES * CH_PER_TYPE,
  localparam int REG_W  = 2 * NCH,
  localparam int TYPE_W = clog2_min1(N_TYPES),
  localparam int IDX_W  = clog2_min1(CH_PER_TYPE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [NCH-1:0]    half_evt_i,
  input  logic [NCH-1:0]    end_evt_i,
  output logic              irq_o,
  output logic              end_valid_o,
  output logic [TYPE_W-1:0] end_type_o,
  output logic [IDX_W-1:0]  end_index_o
);
  logic             sel_en, sel_pend;
  logic [REG_W-1:0] en_q, set_vec, clr_vec, pend;

  assign sel_en   = (reg_addr_i == ADDR_W'(EN_WORD));
  assign sel_pend = (reg_addr_i == ADDR_W'(PEND_WORD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 en_q <= '0;
    else if (reg_wr_i && sel_en) en_q <= reg_wdata_i;
  end

  assign clr_vec = (reg_wr_i && sel_pend) ? reg_wdata_i : '0;

  dma_irq_bitmap #(.NCH(NCH)) u_map (
    .half_i (half_evt_i),
    .end_i  (end_evt_i),
    .set_o  (set_vec)
  );

  dma_irq_pend #(.W(REG_W)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  dma_irq_lowest_end #(.N_TYPES(N_TYPES), .CH_PER_TYPE(CH_PER_TYPE)) u_low (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .valid_o (end_valid_o),
    .type_o  (end_type_o),
    .index_o (end_index_o)
  );

  always_comb begin
    if (sel_en)        reg_rdata_o = en_q;
    else if (sel_pend) reg_rdata_o = pend;
    else               reg_rdata_o = '0;
  end

  assign irq_o = |(pend & en_q);

  assert_en_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && sel_en && reg_wdata_i == '0) |=> !irq_o);

  assert_no_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !irq_o);

  assert_unmapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !sel_en) |=> $stable(en_q));

  assert_event_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_evt_i != '0) |=> end_valid_o);
endmodule

// File: tb/tb_dma_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dma_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] half = '0, endv = '0;
  logic        irq, evalid, etype;
  logic [2:0]  eidx;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .half_evt_i(half),
    .end_evt_i(endv), .irq_o(irq), .end_valid_o(evalid),
    .end_type_o(etype), .end_index_o(eidx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model
  logic [31:0] m_en = '0, m_pend = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      logic [31:0] setm, clrm;
      setm = '0;
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < 8; i++) begin
          if (endv[t*8+i]) setm[t*16+i*2+1] = 1'b1;
          if (half[t*8+i]) setm[t*16+i*2] = 1'b1;
        end
      clrm = (wr && addr == 4'd1) ? wdata : '0;
      m_pend = (m_pend & ~clrm) | setm;
      if (wr && addr == 4'd0) m_en = wdata;
      #1;
      begin
        logic [31:0] exp_rd;
        logic        ev;
        int          p;
        exp_rd = (addr == 4'd0) ? m_en : (addr == 4'd1) ? m_pend : 32'd0;
        check((addr == 4'd0) ? "R6 enable readback" :
              (addr == 4'd1) ? "R2 pending readback" : "R9 unmapped read",
              rdata, exp_rd);
        check("R7 irq", {31'd0, irq}, {31'd0, |(m_pend & m_en)});
        ev = 1'b0; p = 0;
        for (int b = 31; b >= 1; b -= 2)
          if (m_pend[b]) begin ev = 1'b1; p = b + 1; end
        check("R8 end valid", {31'd0, evalid}, {31'd0, ev});
        if (ev) begin
          check("R8 end type", {31'd0, etype}, ((p - 1) / 2) / 8);
          check("R8 end index", {29'd0, eidx}, ((p - 1) / 2) % 8);
        end
      end
    end else begin
      m_en = '0; m_pend = '0;
    end
  end

  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                      input logic [15:0] h, input logic [15:0] e);
    @(negedge clk);
    wr = w; addr = a; wdata = d; half = h; endv = e;
    @(posedge clk); #1.5;
  endtask

  initial begin
    #5;
    addr = 4'd0; #1;
    check("R1 enable reset", rdata, 32'd0);
    addr = 4'd1; #1;
    check("R1 pending reset", rdata, 32'd0);
    check("R1 irq reset", {31'd0, irq}, 32'd0);
    check("R1 helper reset", {31'd0, evalid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    step(0, 4'd1, 0, 16'h0000, 16'h0800);  // group 1 index 3 -> bit 23
    check("R2 end bit position", rdata, 32'h0080_0000);
    check("R3 pending not enabled no irq", {31'd0, irq}, 32'd0);
    check("R8 type", {31'd0, etype}, 32'd1);
    check("R8 index", {29'd0, eidx}, 32'd3);
    step(0, 4'd1, 0, 16'h0001, 16'h0000);
    check("R2 half bit position", rdata, 32'h0080_0001);
    step(1, 4'd0, 32'h0000_0001, 0, 0);
    check("R6 enable write", rdata, 32'h0000_0001);
    check("R7 irq raised", {31'd0, irq}, 32'd1);
    step(1, 4'd1, 32'h0000_0001, 16'h0001, 0);
    check("R5 set beats clear", rdata, 32'h0080_0001);
    step(1, 4'd1, 32'h0000_0001, 0, 0);
    check("R4 w1c", rdata, 32'h0080_0000);
    check("R7 irq dropped", {31'd0, irq}, 32'd0);
    step(0, 4'd1, 0, 0, 16'h0004);
    check("R8 lowest end wins", {29'd0, eidx}, 32'd2);
    check("R8 lowest end type", {31'd0, etype}, 32'd0);
    step(1, 4'd2, 32'hFFFF_FFFF, 0, 0);
    check("R9 unmapped reads zero", rdata, 32'd0);
    step(0, 4'd1, 0, 0, 0);
    check("R9 pending untouched", rdata, 32'h0080_0020);
    step(0, 4'd0, 0, 0, 0);
    check("R9 enable untouched", rdata, 32'h0000_0001);
    step(1, 4'd1, 32'hFFFF_FFFF, 0, 0);
    check("R4 clear all", rdata, 32'd0);
    check("R8 helper idle", {31'd0, evalid}, 32'd0);

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] h, e;
      h = 16'($urandom & $urandom & $urandom);
      e = 16'($urandom & $urandom & $urandom);
      step(($urandom % 3) == 0, 4'($urandom % 4),
           $urandom & $urandom, h, e);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule